// File: doc/BRIEF.md
# Fuse Configuration Store with Read Protection

This block models the configuration memory of a small programmable logic device. It holds the logical state of the programmable cells, not the analog side of programming. There are five storage targets. The first is the AND-array cells. The second is the architecture control word. The third is a 64-bit user signature, whose contents carry no logic meaning. The fourth is a factory signature that is fixed by parameters. The last is a single security cell.

A requester issues one single-bit operation per accepted cycle through a valid/ready handshake. The operation is a read, a program or a bulk erase. A program can only move a stored bit from 1 to 0, and only a bulk erase returns bits to 1. The security cell is active once it has been programmed to 0. While it is active, reads of the AND array are masked and flagged. Every other target stays readable. The factory signature cannot be programmed or erased.

Top module: `fuse_store`

## Requirements
- R1: A request is accepted on a rising edge where `reqValid` and `reqReady` are both 1. `reqReady` is 0 while `rst` is high and is 1 from the first edge after reset onward. Operation codes: 2'b00 read, 2'b01 program, 2'b10 bulk erase, 2'b11 no operation. Target codes: 0 AND array, 1 control word, 2 user signature, 3 factory signature, 4 security cell. Codes 5 to 7 address nothing.
- R2: An accepted read raises `rspValid` for exactly one cycle after its accepting edge, with `rspData` carrying the bit. Any other operation leaves `rspValid` at 0.
- R3: A program clears the addressed bit of the AND array, control word or user signature to 0. No program ever turns a 0 into a 1, and a bit that was not addressed keeps its value.
- R4: A bulk erase sets every bit of the AND array, control word and user signature to 1, and sets the security cell to 1. It takes effect at its accepting edge.
- R5: The factory signature reads as the parameter `FACT_INIT`, with bits 16 to 23 replaced by the 8-bit `DEV_CODE`. Program and bulk erase never change it.
- R6: The security cell (target 4, index 0) reads 1 when inactive. Programming it makes it 0, which means active. Only a bulk erase returns it to 1.
- R7: While security is active, an AND-array read returns `rspData` = 1 and raises `rspProt` for that single response cycle. `rspProt` is 0 on every other response.
- R8: While security is active, reads of the control word, user signature, factory signature and security cell return their stored values.
- R9: An index at or beyond the size of its target, or a target code 5 to 7, reads as 1, and a program to it has no effect. The security cell has size 1.
- R10: After reset, the AND array, control word and user signature hold all ones, and security is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Store can accept a request |
| reqOp | input | 2 | Operation code |
| reqRegion | input | 3 | Target code |
| reqIndex | input | IDX_W | Bit index within the target |
| rspValid | output | 1 | Read response present |
| rspData | output | 1 | Read bit (1 when masked) |
| rspProt | output | 1 | Read was masked by security |

## Verification
Some rules are checked on every cycle by assertions. Stored bits only rise during an erase. An erase leaves all erasable bits at 1. An active security cell stays active until an erase. A protected array read always produces a masked, flagged response, and a read of any other target never raises the flag. Only at most one strobe is ever issued.

The bench's sweeps show the things a property cannot see. It checks the exact value of every bit of every target after each programming pattern. It checks the parameter-built factory word, including the device code in bits 16 to 23. It also shows that out-of-range indices and unused target codes neither store nor return anything but 1, and that a no-operation request changes nothing.

// File: rtl/fuse_store_pkg.sv
package fuse_store_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_PROG  = 2'b01,
    OP_ERASE = 2'b10,
    OP_NOP   = 2'b11
  } fuseOp_e;

  typedef enum logic [2:0] {
    RG_ARRAY = 3'd0,
    RG_CTRL  = 3'd1,
    RG_USER  = 3'd2,
    RG_FACT  = 3'd3,
    RG_SEC   = 3'd4
  } fuseRegion_e;

  typedef struct packed {
    logic        rdEn;
    logic        pgmEn;
    logic        eraseEn;
    fuseRegion_e region;
  } fuseStrobe_t;

  function automatic int maxOf4(int a, int b, int c, int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/fuse_store_ctrl.sv
module fuse_store_ctrl
  import fuse_store_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        reqValid,
  input  logic [1:0]  reqOp,
  input  logic [2:0]  reqRegion,
  output logic        reqReady,
  output fuseStrobe_t strobe
);

  logic readyQ;
  logic accept;

  always_ff @(posedge clk) begin
    if (rst) readyQ <= 1'b0;
    else     readyQ <= 1'b1;
  end

  assign reqReady = readyQ;
  assign accept   = reqValid & readyQ;

  always_comb begin
    strobe.rdEn    = accept && (fuseOp_e'(reqOp) == OP_READ);
    strobe.pgmEn   = accept && (fuseOp_e'(reqOp) == OP_PROG);
    strobe.eraseEn = accept && (fuseOp_e'(reqOp) == OP_ERASE);
    strobe.region  = fuseRegion_e'(reqRegion);
  end

  // R1: once ready, stays ready
  p_ready_held_r1: assert property (@(posedge clk) disable iff (rst)
    reqReady |=> reqReady);

  // R1: never more than one operation per cycle
  p_single_op_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe.rdEn, strobe.pgmEn, strobe.eraseEn}));

  // R1: no strobe without a request
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !reqValid |-> !(strobe.rdEn || strobe.pgmEn || strobe.eraseEn));

endmodule

// File: rtl/fuse_store_datapath.sv
module fuse_store_datapath
  import fuse_store_pkg::*;
#(
  parameter int                 ARRAY_BITS = 128,
  parameter int                 CTRL_BITS  = 18,
  parameter int                 USER_BITS  = 64,
  parameter int                 FACT_BITS  = 64,
  parameter logic [FACT_BITS-1:0] FACT_INIT = 64'h5A3C_9E00_1F00_A5C3,
  parameter logic [7:0]         DEV_CODE   = 8'h3A,
  parameter int                 IDX_W      = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  fuseStrobe_t      strobe,
  input  logic [IDX_W-1:0] index,
  output logic             rspValid,
  output logic             rspData,
  output logic             rspProt
);

  localparam int A_IW = $clog2(ARRAY_BITS > 1 ? ARRAY_BITS : 2);
  localparam int C_IW = $clog2(CTRL_BITS  > 1 ? CTRL_BITS  : 2);
  localparam int U_IW = $clog2(USER_BITS  > 1 ? USER_BITS  : 2);
  localparam int F_IW = $clog2(FACT_BITS  > 1 ? FACT_BITS  : 2);
  localparam logic [FACT_BITS-1:0] CODE_MASK = FACT_BITS'(8'hFF) << 16;
  localparam logic [FACT_BITS-1:0] FACT_WORD =
    (FACT_INIT & ~CODE_MASK) | (FACT_BITS'(DEV_CODE) << 16);

  logic [ARRAY_BITS-1:0] arrayQ;
  logic [CTRL_BITS-1:0]  ctrlQ;
  logic [USER_BITS-1:0]  userQ;
  logic                  secureQ;   // 0 = protection active

  logic inArray, inCtrl, inUser, inFact, inSec;
  logic rdBit, blocked;

  assign inArray = int'(index) < ARRAY_BITS;
  assign inCtrl  = int'(index) < CTRL_BITS;
  assign inUser  = int'(index) < USER_BITS;
  assign inFact  = int'(index) < FACT_BITS;
  assign inSec   = (index == '0);

  // Storage: program clears one bit, erase fills the erasable targets
  always_ff @(posedge clk) begin
    if (rst || strobe.eraseEn) begin
      arrayQ  <= '1;
      ctrlQ   <= '1;
      userQ   <= '1;
      secureQ <= 1'b1;
    end else if (strobe.pgmEn) begin
      unique case (strobe.region)
        RG_ARRAY: if (inArray) arrayQ[index[A_IW-1:0]] <= 1'b0;
        RG_CTRL:  if (inCtrl)  ctrlQ[index[C_IW-1:0]]  <= 1'b0;
        RG_USER:  if (inUser)  userQ[index[U_IW-1:0]]  <= 1'b0;
        RG_SEC:   if (inSec)   secureQ                 <= 1'b0;
        default: ;
      endcase
    end
  end

  // Read selection with array masking
  always_comb begin
    rdBit   = 1'b1;
    blocked = 1'b0;
    unique case (strobe.region)
      RG_ARRAY: begin
        if (inArray) rdBit = arrayQ[index[A_IW-1:0]];
        if (!secureQ) begin
          rdBit   = 1'b1;
          blocked = 1'b1;
        end
      end
      RG_CTRL: if (inCtrl) rdBit = ctrlQ[index[C_IW-1:0]];
      RG_USER: if (inUser) rdBit = userQ[index[U_IW-1:0]];
      RG_FACT: if (inFact) rdBit = FACT_WORD[index[F_IW-1:0]];
      RG_SEC:  if (inSec)  rdBit = secureQ;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rspValid <= 1'b0;
      rspData  <= 1'b0;
      rspProt  <= 1'b0;
    end else begin
      rspValid <= strobe.rdEn;
      rspData  <= strobe.rdEn ? rdBit : 1'b0;
      rspProt  <= strobe.rdEn & blocked;
    end
  end

  // R2: a response follows each accepted read and nothing else
  p_rsp_follows_r2: assert property (@(posedge clk) disable iff (rst)
    strobe.rdEn |=> rspValid);
  p_rsp_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !strobe.rdEn |=> !rspValid);

  // R3: without an erase no stored bit rises
  p_one_way_r3: assert property (@(posedge clk) disable iff (rst)
    !strobe.eraseEn |=> (((arrayQ & ~$past(arrayQ)) == '0) &&
                         ((ctrlQ  & ~$past(ctrlQ))  == '0) &&
                         ((userQ  & ~$past(userQ))  == '0)));

  // R4: erase leaves every erasable bit at 1
  p_erase_fills_r4: assert property (@(posedge clk) disable iff (rst)
    strobe.eraseEn |=> (&arrayQ && &ctrlQ && &userQ && secureQ));

  // R6: active protection persists until an erase
  p_lock_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (!secureQ && !strobe.eraseEn) |=> !secureQ);

  // R7: protected array reads are masked and flagged
  p_mask_r7: assert property (@(posedge clk) disable iff (rst)
    (strobe.rdEn && strobe.region == RG_ARRAY && !secureQ)
      |=> (rspValid && rspProt && rspData));
  p_prot_with_rsp_r7: assert property (@(posedge clk) disable iff (rst)
    rspProt |-> rspValid);

  // R8: other targets are never flagged
  p_open_read_r8: assert property (@(posedge clk) disable iff (rst)
    (strobe.rdEn && strobe.region != RG_ARRAY) |=> !rspProt);

endmodule

// File: rtl/fuse_store.sv
module fuse_store
  import fuse_store_pkg::*;
#(
  parameter int                   ARRAY_BITS = 128,
  parameter int                   CTRL_BITS  = 18,
  parameter int                   USER_BITS  = 64,
  parameter int                   FACT_BITS  = 64,
  parameter logic [FACT_BITS-1:0] FACT_INIT  = 64'h5A3C_9E00_1F00_A5C3,
  parameter logic [7:0]           DEV_CODE   = 8'h3A,
  localparam int IDX_W = $clog2(maxOf4(ARRAY_BITS, CTRL_BITS, USER_BITS, FACT_BITS))
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [1:0]       reqOp,
  input  logic [2:0]       reqRegion,
  input  logic [IDX_W-1:0] reqIndex,
  output logic             rspValid,
  output logic             rspData,
  output logic             rspProt
);

  fuseStrobe_t strobe;

  fuse_store_ctrl i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .reqValid  (reqValid),
    .reqOp     (reqOp),
    .reqRegion (reqRegion),
    .reqReady  (reqReady),
    .strobe    (strobe)
  );

  fuse_store_datapath #(
    .ARRAY_BITS (ARRAY_BITS),
    .CTRL_BITS  (CTRL_BITS),
    .USER_BITS  (USER_BITS),
    .FACT_BITS  (FACT_BITS),
    .FACT_INIT  (FACT_INIT),
    .DEV_CODE   (DEV_CODE),
    .IDX_W      (IDX_W)
  ) i_datapath (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .index    (reqIndex),
    .rspValid (rspValid),
    .rspData  (rspData),
    .rspProt  (rspProt)
  );

endmodule

// File: tb/test_fuse_store.sv
`timescale 1ns/1ps
module test_fuse_store;

  localparam int          NA = 128, NC = 18, NU = 64, NF = 64, IW = 7;
  localparam logic [63:0] FINIT = 64'h5A3C_9E00_1F00_A5C3;
  localparam logic [7:0]  DEV   = 8'h3A;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reqValid = 1'b0;
  logic [1:0] reqOp = 2'b00;
  logic [2:0] reqRegion = 3'd0;
  logic [IW-1:0] reqIndex = '0;
  logic reqReady, rspValid, rspData, rspProt;

  int nChecks = 0;
  int nFail = 0;

  logic [NA-1:0] mArr;
  logic [NC-1:0] mCtl;
  logic [NU-1:0] mUsr;
  logic          mSec;

  always #2 clk = ~clk;

  fuse_store i_fuse_store (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqRegion(reqRegion), .reqIndex(reqIndex),
    .rspValid(rspValid), .rspData(rspData), .rspProt(rspProt)
  );

  function automatic logic factBit(int i);
    if (i >= 16 && i <= 23) return DEV[i-16];
    return FINIT[i];
  endfunction

  task automatic check(string req, logic act, logic exp, string what);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic issue(logic [1:0] op, int rg, int idx);
    @(negedge clk);
    reqValid  = 1'b1;
    reqOp     = op;
    reqRegion = 3'(rg);
    reqIndex  = IW'(idx);
    @(negedge clk);
    reqValid  = 1'b0;
  endtask

  // R2 R7 R8 R9: read one bit and compare to model
  task automatic doRead(int rg, int idx);
    logic eb, ep;
    string tag;
    issue(2'b00, rg, idx);
    eb = 1'b1; ep = 1'b0;
    case (rg)
      0: begin
        if (idx < NA) eb = mArr[idx];
        if (!mSec) begin eb = 1'b1; ep = 1'b1; end
      end
      1: if (idx < NC) eb = mCtl[idx];
      2: if (idx < NU) eb = mUsr[idx];
      3: if (idx < NF) eb = factBit(idx);
      4: if (idx == 0) eb = mSec;
      default: ;
    endcase
    tag = $sformatf("rg%0d idx%0d", rg, idx);
    check("R2", rspValid, 1'b1, {tag, " rspValid"});
    check(rg == 3 ? "R5" : (rg == 0 ? "R3" : "R9"), rspData, eb, {tag, " data"});
    check("R7", rspProt, ep, {tag, " prot"});
  endtask

  task automatic doProg(int rg, int idx);
    issue(2'b01, rg, idx);
    check("R2", rspValid, 1'b0, "no response after program");
    case (rg)
      0: if (idx < NA) mArr[idx] = 1'b0;
      1: if (idx < NC) mCtl[idx] = 1'b0;
      2: if (idx < NU) mUsr[idx] = 1'b0;
      4: if (idx == 0) mSec = 1'b0;
      default: ;
    endcase
  endtask

  task automatic doErase();
    issue(2'b10, 0, 0);
    check("R4", rspValid, 1'b0, "no response after erase");
    mArr = '1; mCtl = '1; mUsr = '1; mSec = 1'b1;
  endtask

  task automatic sweep();
    for (int rg = 0; rg < 8; rg++)
      for (int i = 0; i < (1 << IW); i++)
        doRead(rg, i);
  endtask

  initial begin : watchdog
    #(4 * 200000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin : main
    mArr = '1; mCtl = '1; mUsr = '1; mSec = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", reqReady, 1'b0, "ready low in reset");
    check("R2", rspValid, 1'b0, "rspValid low in reset");
    rst = 1'b0;
    @(negedge clk);
    check("R1", reqReady, 1'b1, "ready after reset");

    // R10 R5 R9: erased state after reset, factory word, unused codes
    sweep();

    // R3 R9: program patterns, including out-of-range and factory attempts
    for (int i = 0; i < NA; i++) if (i % 3 == 0) doProg(0, i);
    for (int i = 0; i < 32; i++) if (i % 2 == 1) doProg(1, i);
    for (int i = 0; i < NU; i++) if ((i * 5) % 7 < 3) doProg(2, i);
    for (int i = 0; i < NF; i++) if (i % 4 == 0) doProg(3, i);
    doProg(4, 5);
    doProg(6, 0);
    sweep();

    // R3: programming again never restores a 1
    for (int i = 0; i < NA; i++) if (i % 3 == 0) doProg(0, i);
    for (int i = 0; i < NA; i += 7) doRead(0, i);

    // R1: no-operation request changes nothing
    issue(2'b11, 0, 1);
    check("R1", rspValid, 1'b0, "nop gives no response");
    doRead(0, 1);
    doRead(0, 0);

    // R6 R7 R8: activate protection
    doProg(4, 0);
    doProg(0, 1);
    sweep();

    // R4 R5 R6: erase clears everything erasable, factory intact
    doErase();
    sweep();
    doRead(4, 0);

    // R3: program then read next cycle after erase
    doProg(2, 63);
    doRead(2, 63);
    doRead(2, 62);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule